// File: doc/BRIEF.md
# I2C Slave Byte Receiver

This block is the receive side of a two-wire serial slave. It watches the clock and data lines through synchronizers and finds the start and stop conditions from edges of those synchronized copies. After a start it shifts in a 7-bit address, most significant bit first, followed by a direction bit. When the address equals the block's own address and the direction is write, the block acknowledges the byte. It then keeps taking data bytes into a single holding register, which a host reads out.

The host side is a set of flags plus three single-cycle strobes: one for "buffer read", one to clear the interrupt and one to clear the overflow flag. The block acknowledges a byte only when the holding register is empty and no overflow is pending. If either condition fails, the slot stays released, the master sees a not-acknowledge and ends the transfer with a stop. The data line is open-drain. The block only asserts an active-low enable, which pulls the line low.

Top module: `i2crx_slave`

## Requirements
- R1: A start condition (data falling while clock is high) always restarts address reception, even in the middle of a transfer or when repeated without a stop. A stop condition (data rising while clock is high) returns the block to idle. In idle, clock pulses are ignored: no acknowledge is driven and no flag changes.
- R2: An address byte whose upper seven bits equal `own_addr` and whose direction bit (bit 0, the eighth bit on the wire) is 0 is acknowledged if the buffer is empty and no overflow is pending. In that case the byte `{own_addr,1'b0}` is placed in `rx_data`, `buf_full` becomes 1 and `rw_last` becomes 0.
- R3: An address that does not match is not acknowledged and raises no flag. Every byte that follows it is ignored until the next start.
- R4: A matching address with direction bit 1 is not acknowledged. It sets `rw_last` to 1, leaves `rx_data`, `buf_full` and `irq` unchanged, and the following bytes are ignored until the next start.
- R5: `irq` is set by every byte that completes after a matching write address, the address byte included, whether the byte is accepted or rejected. It stays 1 until a `host_clr_irq` strobe.
- R6: A data byte that completes while the buffer is empty and no overflow is pending is acknowledged, loaded into `rx_data`, and sets `buf_full`.
- R7: A byte that completes while `buf_full` is 1 sets `ovf_flag` and is not acknowledged. `rx_data` keeps its previous value.
- R8: `ovf_flag` is sticky. A buffer read does not clear it, and only a `host_clr_ovf` strobe does. While it is 1, every byte is refused with a not-acknowledge, including a matching address.
- R9: A `host_rd` strobe clears `buf_full` and leaves `rx_data` unchanged.
- R10: `sda_oe_n` goes low only in the ninth clock slot of an acknowledged byte. It falls on the clock's falling edge after the eighth bit and is released on the falling edge after the ninth. It is 1 during address and data bits. After reset the flags are 0 and `sda_oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line |
| own_addr | input | ADDR_W | Slave address to answer to |
| host_rd | input | 1 | Strobe: host has read `rx_data` |
| host_clr_irq | input | 1 | Strobe: clear `irq` |
| host_clr_ovf | input | 1 | Strobe: clear `ovf_flag` |
| rx_data | output | ADDR_W+1 | Holding register contents |
| buf_full | output | 1 | Holding register holds an unread byte |
| ovf_flag | output | 1 | Sticky overflow indication |
| rw_last | output | 1 | Direction bit of the last matching address |
| irq | output | 1 | Byte-event interrupt flag |

## Verification
The bench first runs directed transactions that each isolate one decision. These are a foreign address, a read-direction address, a byte arriving into a full buffer, a transaction attempted while overflow is still pending after a read, clock pulses with no preceding start, and a repeated start. Together they separate the acknowledge paths driven by address match, by direction and by buffer state. A seeded random phase then runs transactions with random data bytes, and randomly either reads the buffer or skips the read before each byte, and randomly clears overflow between transactions. A bench model predicts acknowledge, holding data, full and overflow from those choices, which exposes errors in the ordering between host strobes and byte completion. Every data bit also checks that the line is never pulled outside the acknowledge slot.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_ACK  = 3'd3,
    ST_SKIP = 3'd4
  } rx_state_t;

endpackage

// File: rtl/i2crx_sync.sv
module i2crx_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] now,
  output logic [LINES-1:0] prev
);

  // The lines idle high, so every stage resets to 1.
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe    <= '1;
          prev[g] <= 1'b1;
        end else begin
          pipe    <= {pipe[STAGES-2:0], raw[g]};
          prev[g] <= pipe[STAGES-1];
        end
      end
      assign now[g] = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2crx_frame.sv
module i2crx_frame
  import i2crx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_now,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              accept,
  output logic              sda_oe_n,
  output logic              evt_wr_addr,
  output logic              evt_rd_addr,
  output logic              evt_data,
  output logic [ADDR_W:0]   byte_now
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_t         st;
  logic [BYTE_W-2:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              ack_on;
  logic              shifting;
  logic              byte_done;
  logic              addr_hit;
  logic              give_ack;

  assign shifting    = (st == ST_ADDR) || (st == ST_DATA);
  assign byte_done   = shifting && scl_rise && (bitcnt == LAST_BIT);
  assign byte_now    = {shreg, sda_now};
  assign addr_hit    = (byte_now[BYTE_W-1:1] == own_addr);
  assign evt_wr_addr = byte_done && (st == ST_ADDR) && addr_hit && !byte_now[0];
  assign evt_rd_addr = byte_done && (st == ST_ADDR) && addr_hit &&  byte_now[0];
  assign evt_data    = byte_done && (st == ST_DATA);
  assign give_ack    = (evt_wr_addr || evt_data) && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      ack_on   <= 1'b0;
      sda_oe_n <= 1'b1;
    end else if (start_det) begin
      st       <= ST_ADDR;
      bitcnt   <= '0;
      ack_on   <= 1'b0;
      sda_oe_n <= 1'b1;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      ack_on   <= 1'b0;
      sda_oe_n <= 1'b1;
    end else begin
      case (st)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            shreg <= byte_now[BYTE_W-2:0];
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              st     <= give_ack ? ST_ACK : ST_SKIP;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              ack_on   <= 1'b1;
              sda_oe_n <= 1'b0;
            end else begin
              ack_on   <= 1'b0;
              sda_oe_n <= 1'b1;
              st       <= ST_DATA;
              bitcnt   <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2crx_host.sv
module i2crx_host #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_wr_addr,
  input  logic              evt_rd_addr,
  input  logic              evt_data,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              host_rd,
  input  logic              host_clr_irq,
  input  logic              host_clr_ovf,
  output logic              can_accept,
  output logic              buf_load,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovf_flag,
  output logic              rw_last,
  output logic              irq
);

  logic take;

  assign take       = evt_wr_addr || evt_data;
  assign can_accept = !buf_full && !ovf_flag;
  assign buf_load   = take && can_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      ovf_flag <= 1'b0;
      rw_last  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (host_rd) buf_full <= 1'b0;
      if (buf_load) begin
        rx_data  <= byte_in;
        buf_full <= 1'b1;
      end
      if (host_clr_ovf)        ovf_flag <= 1'b0;
      if (take && !can_accept) ovf_flag <= 1'b1;
      if (host_clr_irq) irq <= 1'b0;
      if (take)         irq <= 1'b1;
      if (evt_wr_addr) rw_last <= 1'b0;
      if (evt_rd_addr) rw_last <= 1'b1;
    end
  end

endmodule

// File: rtl/i2crx_slave.sv
module i2crx_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              host_rd,
  input  logic              host_clr_irq,
  input  logic              host_clr_ovf,
  output logic [ADDR_W:0]   rx_data,
  output logic              buf_full,
  output logic              ovf_flag,
  output logic              rw_last,
  output logic              irq
);

  localparam int BYTE_W = ADDR_W + 1;

  logic [1:0]        line_now, line_prev;
  logic              scl_now, scl_prev, sda_now, sda_prev;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              evt_wr_addr, evt_rd_addr, evt_data;
  logic [BYTE_W-1:0] byte_now;
  logic              can_accept, buf_load;

  i2crx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  ({sda_in, scl_in}),
    .now  (line_now),
    .prev (line_prev)
  );

  assign scl_now   = line_now[0];
  assign sda_now   = line_now[1];
  assign scl_prev  = line_prev[0];
  assign sda_prev  = line_prev[1];
  assign scl_rise  =  scl_now && !scl_prev;
  assign scl_fall  = !scl_now &&  scl_prev;
  assign start_det = scl_now && scl_prev &&  sda_prev && !sda_now;
  assign stop_det  = scl_now && scl_prev && !sda_prev &&  sda_now;

  i2crx_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_now     (sda_now),
    .own_addr    (own_addr),
    .accept      (can_accept),
    .sda_oe_n    (sda_oe_n),
    .evt_wr_addr (evt_wr_addr),
    .evt_rd_addr (evt_rd_addr),
    .evt_data    (evt_data),
    .byte_now    (byte_now)
  );

  i2crx_host #(.BYTE_W(BYTE_W)) u_host (
    .clk          (clk),
    .rst          (rst),
    .evt_wr_addr  (evt_wr_addr),
    .evt_rd_addr  (evt_rd_addr),
    .evt_data     (evt_data),
    .byte_in      (byte_now),
    .host_rd      (host_rd),
    .host_clr_irq (host_clr_irq),
    .host_clr_ovf (host_clr_ovf),
    .can_accept   (can_accept),
    .buf_load     (buf_load),
    .rx_data      (rx_data),
    .buf_full     (buf_full),
    .ovf_flag     (ovf_flag),
    .rw_last      (rw_last),
    .irq          (irq)
  );

endmodule

// File: rtl/i2crx_checker.sv
module i2crx_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_fall,
  input logic              start_det,
  input logic              sda_oe_n,
  input logic              host_rd,
  input logic              host_clr_irq,
  input logic              host_clr_ovf,
  input logic              buf_load,
  input logic [BYTE_W-1:0] rx_data,
  input logic              buf_full,
  input logic              ovf_flag,
  input logic              irq
);

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_n) |-> $past(scl_fall)); // R10

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    start_det |=> sda_oe_n); // R1

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    irq && !host_clr_irq |=> irq); // R5

  AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    buf_full |=> $stable(rx_data)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !host_clr_ovf |=> ovf_flag); // R8

  AST_NO_ACK_IN_OVF: assert property (@(posedge clk) disable iff (rst)
    !sda_oe_n |-> !ovf_flag); // R8

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    host_rd && !buf_load |=> !buf_full); // R9

endmodule

bind i2crx_slave i2crx_checker #(.BYTE_W(ADDR_W + 1)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .scl_fall     (scl_fall),
  .start_det    (start_det),
  .sda_oe_n     (sda_oe_n),
  .host_rd      (host_rd),
  .host_clr_irq (host_clr_irq),
  .host_clr_ovf (host_clr_ovf),
  .buf_load     (buf_load),
  .rx_data      (rx_data),
  .buf_full     (buf_full),
  .ovf_flag     (ovf_flag),
  .irq          (irq)
);

// File: tb/sim_i2crx_slave.sv
`timescale 1ns/1ps
module sim_i2crx_slave;

  localparam int AW = 7;
  localparam int Q  = 6;
  localparam logic [AW-1:0] MY_ADDR = 7'h2D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_n;
  logic host_rd = 1'b0, host_clr_irq = 1'b0, host_clr_ovf = 1'b0;
  logic [AW:0] rx_data;
  logic buf_full, ovf_flag, rw_last, irq;
  logic sda_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int drive_errs = 0;

  // Bench model of the host-visible state
  bit         m_full, m_ovf;
  logic [7:0] m_buf;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & sda_oe_n;

  i2crx_slave #(.SYNC_STAGES(2), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe_n(sda_oe_n), .own_addr(MY_ADDR),
    .host_rd(host_rd), .host_clr_irq(host_clr_irq), .host_clr_ovf(host_clr_ovf),
    .rx_data(rx_data), .buf_full(buf_full), .ovf_flag(ovf_flag),
    .rw_last(rw_last), .irq(irq)
  );

  function automatic bit exp_ack(bit full, bit ovf);
    return !(full || ovf);
  endfunction

  function automatic logic [7:0] addr_byte(logic [AW-1:0] a, bit rw);
    return {a, rw};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: host_rd = 1'b1;
      1: host_clr_irq = 1'b1;
      default: host_clr_ovf = 1'b1;
    endcase
    @(negedge clk);
    host_rd = 1'b0; host_clr_irq = 1'b0; host_clr_ovf = 1'b0;
    wclk(1);
  endtask

  task automatic do_start();
    @(negedge clk);
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic do_stop();
    @(negedge clk);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q);
      scl_m = 1'b1; wclk(Q/2);
      if (!sda_oe_n) drive_errs++;
      wclk(Q/2);
      scl_m = 1'b0; wclk(Q);
    end
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q/2);
    acked = !sda_oe_n;
    wclk(Q/2);
    scl_m = 1'b0; wclk(Q);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit ack;
    void'($urandom(32'h5EED_1234));
    wclk(4);
    rst = 1'b0;
    wclk(4);

    // Reset state
    chk("R10 reset oe_n", sda_oe_n, 1);
    chk("R10 reset full", buf_full, 0);
    chk("R10 reset ovf", ovf_flag, 0);
    chk("R10 reset irq", irq, 0);

    // R3: foreign address, then a byte that must be ignored
    do_start();
    send_byte(addr_byte(7'h13, 1'b0), ack);
    chk("R3 nack foreign addr", ack, 0);
    send_byte(8'hA5, ack);
    chk("R3 ignore after mismatch", ack, 0);
    chk("R3 irq quiet", irq, 0);
    chk("R3 full quiet", buf_full, 0);
    do_stop();

    // R2: matching write address
    do_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk("R2 ack", ack, exp_ack(1'b0, 1'b0));
    chk("R2 rx_data", rx_data, addr_byte(MY_ADDR, 1'b0));
    chk("R2 full", buf_full, 1);
    chk("R2 rw_last", rw_last, 0);
    chk("R5 irq on address", irq, 1);

    // R7: data byte into a full buffer
    send_byte(8'h3C, ack);
    chk("R7 nack when full", ack, 0);
    chk("R7 ovf set", ovf_flag, 1);
    chk("R7 data kept", rx_data, addr_byte(MY_ADDR, 1'b0));
    do_stop();

    // R8 / R9: read clears full, not overflow; overflow still refuses
    pulse(0);
    chk("R9 read clears full", buf_full, 0);
    chk("R9 read keeps data", rx_data, addr_byte(MY_ADDR, 1'b0));
    chk("R8 ovf survives read", ovf_flag, 1);
    do_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk("R8 nack while ovf", ack, 0);
    chk("R8 no load while ovf", buf_full, 0);
    do_stop();
    pulse(2);
    chk("R8 clear ovf", ovf_flag, 0);
    chk("R5 irq held", irq, 1);
    pulse(1);
    chk("R5 clear irq", irq, 0);

    // R6: accepted data byte
    do_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk("R2 ack again", ack, 1);
    pulse(0);
    pulse(1);
    send_byte(8'h5A, ack);
    chk("R6 ack data", ack, 1);
    chk("R6 rx_data", rx_data, 8'h5A);
    chk("R6 full", buf_full, 1);
    chk("R5 irq on data", irq, 1);
    pulse(0);
    do_stop();
    pulse(1);

    // R4: read-direction address
    do_start();
    send_byte(addr_byte(MY_ADDR, 1'b1), ack);
    chk("R4 nack read dir", ack, 0);
    chk("R4 rw_last", rw_last, 1);
    chk("R4 irq unchanged", irq, 0);
    chk("R4 data unchanged", rx_data, 8'h5A);
    chk("R4 full unchanged", buf_full, 0);
    do_stop();

    // R1: clock pulses with no start are ignored
    @(negedge clk); scl_m = 1'b0; wclk(Q);
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk("R1 idle ignores", ack, 0);
    chk("R1 idle irq", irq, 0);

    // R1: repeated start without stop
    do_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk("R1 first addr ack", ack, 1);
    chk("R1 rw_last back to 0", rw_last, 0);
    pulse(0);
    do_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), ack);
    chk("R1 repeated start ack", ack, 1);
    pulse(0);
    pulse(1);
    do_stop();

    // Random transactions against the bench model
    m_full = 1'b0; m_ovf = 1'b0; m_buf = addr_byte(MY_ADDR, 1'b0);
    for (int t = 0; t < 24; t++) begin
      bit ea;
      int nbytes;
      pulse(1);
      do_start();
      ea = exp_ack(m_full, m_ovf);
      send_byte(addr_byte(MY_ADDR, 1'b0), ack);
      chk("R2 random addr ack", ack, ea);
      if (ea) begin m_full = 1'b1; m_buf = addr_byte(MY_ADDR, 1'b0); end
      else m_ovf = 1'b1;
      chk("R5 random irq", irq, 1);
      nbytes = 1 + int'($urandom_range(2));
      for (int k = 0; k < nbytes && ack; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if ($urandom_range(3) != 0) begin pulse(0); m_full = 1'b0; end
        ea = exp_ack(m_full, m_ovf);
        send_byte(d, ack);
        chk("R6 random data ack", ack, ea);
        if (ea) begin m_full = 1'b1; m_buf = d; end
        else m_ovf = 1'b1;
        chk("R7 random rx_data", rx_data, m_buf);
        chk("R7 random ovf", ovf_flag, m_ovf);
        chk("R9 random full", buf_full, m_full);
      end
      do_stop();
      if ($urandom_range(1) == 1) begin pulse(2); m_ovf = 1'b0; end
      if ($urandom_range(1) == 1) begin pulse(0); m_full = 1'b0; end
      chk("R8 random ovf after stop", ovf_flag, m_ovf);
    end

    chk("R10 no drive during bits", drive_errs, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule